// File: doc/BRIEF.md
# Floppy Status Override Register

This block is one configuration-space register, plus the decode around it, that lets software make a floppy drive look as if its disk was changed or its medium is write protected. Each of two drives has its own override. Software reaches the register through an index/data pair. The block sees the value already held in the index register (`idx_i`) and a data-port write strobe. A write takes effect only while the chip is in configuration state and the index equals 17h. A read returns the register only under that same condition.

The disk-change overrides can be set by software but cannot be cleared by it. Each one clears itself when the step line and that drive's select line are both high together. The write-protect overrides are plain read/write bits.

The block mixes the overrides with the live drive-select and drive status inputs. Its two results feed both the floppy interface pins and the parallel-port floppy path:

- the disk-change bit of the floppy digital input register;
- the effective write-protect signal.

Indices 18h to 1Dh are reserved. Writes to them do nothing and reads of them return 00h.

Top module: `fdd_status_force`

## Requirements
- R1: After reset, a read at index 17h in configuration state returns 03h: both disk-change overrides are set and both write-protect overrides are clear.
- R2: The register layout at index 17h is as follows:
  - bit 0 is the drive-0 disk-change override;
  - bit 1 is the drive-1 disk-change override;
  - bit 2 is the drive-0 write-protect override;
  - bit 3 is the drive-1 write-protect override;
  - bits 7:4 always read 0.

  A write at index 17h in configuration state loads bits 3:2 from the write data.
- R3: Writing 1 to bit 0 or bit 1 sets that disk-change override. Writing 0 to it leaves it unchanged.
- R4: At every clock edge where `step_i` is 1 and `ds_ni[n]` is 1, the disk-change override of drive n is cleared.
- R5: If a hardware clear and a software write of 1 hit the same disk-change override in the same cycle, the override ends up cleared.
- R6: `dskchg_o` = (`ds_ni[0]` AND override bit 0) OR (`ds_ni[1]` AND override bit 1) OR `dskchg_ni`. It is combinational.
- R7: `wrtprt_o` = (`ds_ni[0]` AND override bit 2) OR (`ds_ni[1]` AND override bit 3) OR `wrtprt_ni`. It is combinational.
- R8: Writes at indices 18h to 1Dh leave the register unchanged, and reads at those indices return 00h.
- R9: When configuration state is inactive, data-port writes are ignored and reads return 00h.
- R10: Writes at any index other than 17h leave the register unchanged, and reads at those indices return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration state is active |
| idx_i | input | 8 | Current value of the index register |
| wr_en_i | input | 1 | Data-port write strobe |
| wdata_i | input | 8 | Data-port write data |
| rdata_o | output | 8 | Data-port read data |
| step_i | input | 1 | Step line. A high level together with a high drive select clears that drive's disk-change override |
| ds_ni | input | 2 | Drive-select lines, one bit per drive (bit n is drive n) |
| dskchg_ni | input | 1 | Live disk-change input from the drive |
| wrtprt_ni | input | 1 | Live write-protect input from the drive |
| dskchg_o | output | 1 | Disk-change bit for the digital input register |
| wrtprt_o | output | 1 | Effective write-protect |

## Verification
The software set path and the hardware clear path of a disk-change override can act in the same cycle.

The bench provokes this by holding `step_i` and the drive-0 select high during the very cycle in which it writes 1 to bit 0. It then reads the register back in the next cycle.

It expects bit 0 to be cleared. It also expects drive 1's override, whose select was low at that edge, to be left untouched.

// File: rtl/fdd_status_force_pkg.sv
package fdd_status_force_pkg;
  parameter int IDX_W      = 8;
  parameter int DATA_W     = 8;
  parameter int NUM_DRIVES = 2;
  localparam int FORCE_W   = 2 * NUM_DRIVES;
  parameter logic [IDX_W-1:0]   FORCE_IDX = 8'h17;
  parameter logic [FORCE_W-1:0] FORCE_RST = 4'h3;
endpackage

// File: rtl/fsf_decode.sv
module fsf_decode
  import fdd_status_force_pkg::*;
(
  input  logic                 cfg_mode_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 wr_en_i,
  input  logic [FORCE_W-1:0]   force_i,
  output logic                 wr_hit_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic sel;

  // Reserved and foreign indices fall through to zero.
  assign sel      = cfg_mode_i && (idx_i == FORCE_IDX);
  assign wr_hit_o = sel && wr_en_i;

  always_comb begin
    rdata_o = '0;
    if (sel) rdata_o[FORCE_W-1:0] = force_i;
  end
endmodule

// File: rtl/fsf_force_reg.sv
module fsf_force_reg
  import fdd_status_force_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_hit_i,
  input  logic [FORCE_W-1:0]    wbits_i,
  input  logic                  step_i,
  input  logic [NUM_DRIVES-1:0] ds_ni,
  output logic [FORCE_W-1:0]    force_o
);
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic clr;
    assign clr = step_i && ds_ni[d];

    // Disk-change override: set-only from software, the hardware clear wins.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        force_o[d] <= FORCE_RST[d];
      else if (clr)                       force_o[d] <= 1'b0;
      else if (wr_hit_i && wbits_i[d])    force_o[d] <= 1'b1;
    end

    // Write-protect override: plain read/write bit.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       force_o[NUM_DRIVES+d] <= FORCE_RST[NUM_DRIVES+d];
      else if (wr_hit_i) force_o[NUM_DRIVES+d] <= wbits_i[NUM_DRIVES+d];
    end
  end
endmodule

// File: rtl/fsf_status_mix.sv
module fsf_status_mix
  import fdd_status_force_pkg::*;
(
  input  logic [FORCE_W-1:0]    force_i,
  input  logic [NUM_DRIVES-1:0] ds_ni,
  input  logic                  dskchg_ni,
  input  logic                  wrtprt_ni,
  output logic                  dskchg_o,
  output logic                  wrtprt_o
);
  logic [NUM_DRIVES-1:0] dc_term, wp_term;

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_term
    assign dc_term[d] = ds_ni[d] && force_i[d];
    assign wp_term[d] = ds_ni[d] && force_i[NUM_DRIVES+d];
  end

  assign dskchg_o = (|dc_term) || dskchg_ni;
  assign wrtprt_o = (|wp_term) || wrtprt_ni;
endmodule

// File: rtl/fdd_status_force.sv
module fdd_status_force
  import fdd_status_force_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_mode_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  step_i,
  input  logic [NUM_DRIVES-1:0] ds_ni,
  input  logic                  dskchg_ni,
  input  logic                  wrtprt_ni,
  output logic                  dskchg_o,
  output logic                  wrtprt_o
);
  logic               wr_hit;
  logic [FORCE_W-1:0] force_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:FORCE_W];

  fsf_decode u_dec (
    .cfg_mode_i (cfg_mode_i),
    .idx_i      (idx_i),
    .wr_en_i    (wr_en_i),
    .force_i    (force_q),
    .wr_hit_o   (wr_hit),
    .rdata_o    (rdata_o)
  );

  fsf_force_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wbits_i  (wdata_i[FORCE_W-1:0]),
    .step_i   (step_i),
    .ds_ni    (ds_ni),
    .force_o  (force_q)
  );

  fsf_status_mix u_mix (
    .force_i   (force_q),
    .ds_ni     (ds_ni),
    .dskchg_ni (dskchg_ni),
    .wrtprt_ni (wrtprt_ni),
    .dskchg_o  (dskchg_o),
    .wrtprt_o  (wrtprt_o)
  );
endmodule

// File: rtl/fdd_status_force_chk.sv
module fdd_status_force_chk
  import fdd_status_force_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cfg_mode_i,
  input logic [IDX_W-1:0]      idx_i,
  input logic                  wr_en_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic                  step_i,
  input logic [NUM_DRIVES-1:0] ds_ni,
  input logic                  dskchg_ni,
  input logic                  wrtprt_ni,
  input logic                  dskchg_o,
  input logic                  wrtprt_o,
  input logic [FORCE_W-1:0]    force_q
);
  logic wr17;
  assign wr17 = cfg_mode_i && wr_en_i && (idx_i == FORCE_IDX);

  a_r2_wp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr17 |=> force_q[3:2] == $past(wdata_i[3:2]));

  a_r3_dc0_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_q[0] && !(step_i && ds_ni[0])) |=> force_q[0]);

  a_r4_dc0_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ds_ni[0]) |=> !force_q[0]);

  a_r4_dc1_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ds_ni[1]) |=> !force_q[1]);

  a_r6_dskchg_mix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dskchg_o == ((ds_ni[0] && force_q[0]) || (ds_ni[1] && force_q[1]) || dskchg_ni));

  a_r7_wrtprt_mix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrtprt_o == ((ds_ni[0] && force_q[2]) || (ds_ni[1] && force_q[3]) || wrtprt_ni));

  a_r9_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |-> rdata_o == '0);

  a_r10_no_stray_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr17 |=> $stable(force_q[3:2]));
endmodule

bind fdd_status_force fdd_status_force_chk u_chk (.*);

// File: tb/sim_fdd_status_force.sv
module sim_fdd_status_force;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_mode_i = 1'b0;
  logic [7:0] idx_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       step_i = 1'b0;
  logic [1:0] ds_ni = 2'b11;
  logic       dskchg_ni = 1'b0;
  logic       wrtprt_ni = 1'b0;
  logic       dskchg_o, wrtprt_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fdd_status_force u0 (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic cfg, input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    cfg_mode_i = cfg; idx_i = idx; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic cfg, input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    cfg_mode_i = cfg; idx_i = idx;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, 8'h17, v); check("R1 reset value", v, 8'h03);
    ds_ni = 2'b11; dskchg_ni = 1'b0; wrtprt_ni = 1'b0; #1;
    check("R6 dskchg forced", {7'b0, dskchg_o}, 8'h01);
    check("R7 wrtprt clear", {7'b0, wrtprt_o}, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] v;
    wr(1'b1, 8'h17, 8'hFC);
    rd(1'b1, 8'h17, v); check("R2 wp load, upper zero", v, 8'h0F);
    ds_ni = 2'b10; #1;
    check("R7 wp via drive1", {7'b0, wrtprt_o}, 8'h01);
    wr(1'b1, 8'h17, 8'h04);
    rd(1'b1, 8'h17, v); check("R3 dc not cleared by 0", v, 8'h07);
    ds_ni = 2'b00; #1;
    check("R7 no select", {7'b0, wrtprt_o}, 8'h00);
    wrtprt_ni = 1'b1; #1;
    check("R7 live input", {7'b0, wrtprt_o}, 8'h01);
    wrtprt_ni = 1'b0; ds_ni = 2'b11;
  endtask

  task automatic t_hwclr();
    logic [7:0] v;
    @(negedge clk_i); step_i = 1'b1; ds_ni = 2'b01;
    @(negedge clk_i); step_i = 1'b0; ds_ni = 2'b11;
    rd(1'b1, 8'h17, v); check("R4 clear drive0", v, 8'h06);
    @(negedge clk_i); step_i = 1'b1; ds_ni = 2'b10;
    @(negedge clk_i); step_i = 1'b0; ds_ni = 2'b11;
    rd(1'b1, 8'h17, v); check("R4 clear drive1", v, 8'h04);
    #1 check("R6 no force", {7'b0, dskchg_o}, 8'h00);
    dskchg_ni = 1'b1; #1;
    check("R6 live input", {7'b0, dskchg_o}, 8'h01);
    dskchg_ni = 1'b0;
    wr(1'b1, 8'h17, 8'h03);
    rd(1'b1, 8'h17, v); check("R3 sw set dc", v, 8'h03);
  endtask

  task automatic t_race();
    logic [7:0] v;
    @(negedge clk_i);
    cfg_mode_i = 1'b1; idx_i = 8'h17; wdata_i = 8'h01; wr_en_i = 1'b1;
    step_i = 1'b1; ds_ni = 2'b01;
    @(negedge clk_i);
    wr_en_i = 1'b0; step_i = 1'b0; ds_ni = 2'b11;
    rd(1'b1, 8'h17, v); check("R5 clear beats set", v, 8'h02);
  endtask

  task automatic t_rsv();
    logic [7:0] v;
    for (int i = 8'h18; i <= 8'h1D; i++) begin
      wr(1'b1, 8'(i), 8'hFF);
      rd(1'b1, 8'(i), v); check("R8 reserved reads zero", v, 8'h00);
    end
    rd(1'b1, 8'h17, v); check("R8 reserved write ignored", v, 8'h02);
    wr(1'b1, 8'h16, 8'hFF);
    rd(1'b1, 8'h16, v); check("R10 other index reads zero", v, 8'h00);
    rd(1'b1, 8'h17, v); check("R10 other index write ignored", v, 8'h02);
  endtask

  task automatic t_nocfg();
    logic [7:0] v;
    wr(1'b0, 8'h17, 8'hFF);
    rd(1'b0, 8'h17, v); check("R9 read zero outside cfg", v, 8'h00);
    rd(1'b1, 8'h17, v); check("R9 write ignored outside cfg", v, 8'h02);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_wp();
    t_hwclr();
    t_race();
    t_rsv();
    t_nocfg();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule